// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single internal access requests into cycles on an external memory bus. The bus is carried by three byte-wide bidirectional ports: `p0`, `p1` and `p2`. Two configuration function bits and two configuration control bits choose one of four pin layouts. Each layout mixes dedicated address ports with ports that carry the address first and the data afterwards. The four layouts trade address reach (24, 16 or 8 address bits) against data width (8 or 16 bits).

An external cycle runs in a fixed order:
- one clock of address phase with the address latch strobe high;
- one turnaround clock;
- two clocks of data phase with the read or write strobe low;
- a one-clock done pulse.

A request flagged as internal finishes at once. It causes no strobe, the shared pins float, and the dedicated address ports keep showing the last external address. Until a legal configuration is written, every port stays an input. A request made in that state finishes with an error flag.

Top module: `xbus_mux_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, `ale` is 0, `rd_n` and `wr_n` are 1, `done` and `err` are 0, `ready` is 1, and all three output enables are 0.
- R2: The layout is legal only when `cfg_p1_fn` and `cfg_p2_fn` are both 1. Legal layouts are decoded as follows:
  - `cfg_p1_ctl`=0 makes `p1` a dedicated address port.
  - `cfg_p1_ctl`=1 makes `p1` a shared address/data port.
  - `cfg_p2_ctl`=1 makes `p2` carry address bits 23:16.
  - `cfg_p2_ctl`=0 makes `p2` carry address bits 7:0.
  - Any other setting leaves the bus unconfigured, and then all output enables are 0.
- R3: In the clock after an external request is accepted, `ale` is 1 for exactly that one clock. The next clock is a turnaround with both strobes high. Then, for two clocks, `rd_n` is low on a read or `wr_n` is low on a write. The two strobes are never low together.
- R4: `done` is 1 for exactly one clock:
  - for an external cycle, in the clock after the second data clock;
  - for an internal or unconfigured request, in the clock after acceptance.
  - `ready` is 1 only when no request is in progress, and a request is accepted when `req_valid` and `ready` are both 1.
- R5: A read samples the shared pins at the end of the second data clock. `rdata` holds the sampled value from the done clock onward:
  - 8-bit layouts give `{8'h00, p0_in}`;
  - 16-bit layouts give `{p1_in, p0_in}`.
- R6: During the data phase of a write, `p0` drives `wdata[7:0]`, and in 16-bit layouts `p1` drives `wdata[15:0]`'s upper byte. During the turnaround, and during the data phase of a read, the shared ports are not driven.
- R7: During the address phase, `p0` drives address bits 7:0, and a shared `p1` drives address bits 15:8. This holds in every legal layout.
- R8: When the bus is configured, the dedicated address ports are always driven from the last external address. A dedicated `p1` carries bits 15:8, and `p2` carries the bits chosen in R2.
- R9: An internal request produces no strobe and no shared-pin drive, and gives `err`=0. The dedicated address ports keep the address of the previous external cycle.
- R10: A request made while the bus is unconfigured completes with `done` and `err` both 1 for one clock, and produces no strobe and no pin drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_p1_fn | input | 1 | Port 1 bus-function enable |
| cfg_p1_ctl | input | 1 | Port 1 role: 0 dedicated address, 1 shared |
| cfg_p2_fn | input | 1 | Port 2 bus-function enable |
| cfg_p2_ctl | input | 1 | Port 2 role: 1 upper address byte, 0 low address byte |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_internal | input | 1 | Access targets an internal area |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Idle, can accept a request |
| done | output | 1 | Request complete pulse |
| err | output | 1 | Request made while unconfigured (with done) |
| rdata | output | 16 | Captured read data |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| p0_in | input | 8 | Port 0 pin input |
| p0_out | output | 8 | Port 0 pin output |
| p0_oe | output | 1 | Port 0 output enable |
| p1_in | input | 8 | Port 1 pin input |
| p1_out | output | 8 | Port 1 pin output |
| p1_oe | output | 1 | Port 1 output enable |
| p2_in | input | 8 | Port 2 pin input (unused by the bus) |
| p2_out | output | 8 | Port 2 pin output |
| p2_oe | output | 1 | Port 2 output enable |

## Verification
Some rules are checked by assertions on every cycle:
- the two strobes are never low together;
- `ale` lasts one clock and is followed by a quiet turnaround;
- `done` is a single pulse that returns to `ready`;
- `err` never appears without `done`;
- an unconfigured decode never drives a pin;
- a dedicated port 1 is always enabled;
- port 0 is never driven while `rd_n` is low.

Other behaviour only shows in the bench's scenarios:
- which address byte each port carries in each of the four layouts;
- the read data captured from the pins;
- the written data;
- that the address is held across internal accesses.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    LAY_OFF     = 3'd0,
    LAY_A24_D8  = 3'd1,
    LAY_A24_D16 = 3'd2,
    LAY_A16_D8  = 3'd3,
    LAY_A8_D16  = 3'd4
  } layout_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_TURN = 3'd2,
    PH_DAT1 = 3'd3,
    PH_DAT2 = 3'd4,
    PH_DONE = 3'd5
  } phase_e;

endpackage

// File: rtl/xbus_cfg_decode.sv
module xbus_cfg_decode
  import xbus_pkg::*;
(
  input  logic    p1_fn,
  input  logic    p1_ctl,
  input  logic    p2_fn,
  input  logic    p2_ctl,
  output layout_e layout
);

  always_comb begin
    layout = LAY_OFF;
    if (p1_fn && p2_fn) begin
      unique case ({p1_ctl, p2_ctl})
        2'b01:   layout = LAY_A24_D8;
        2'b11:   layout = LAY_A24_D16;
        2'b00:   layout = LAY_A16_D8;
        default: layout = LAY_A8_D16;
      endcase
    end
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  input  logic   req_internal,
  input  logic   cfg_ok,
  output phase_e phase,
  output logic   wr_cyc,
  output logic   load_ext,
  output logic   capture,
  output logic   ready,
  output logic   ale,
  output logic   rd_n,
  output logic   wr_n,
  output logic   done,
  output logic   err
);

  phase_e phase_q, phase_d;
  logic   wr_q, wr_d;
  logic   err_q, err_d;
  logic   in_data;

  always_comb begin
    phase_d  = phase_q;
    wr_d     = wr_q;
    err_d    = err_q;
    load_ext = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        err_d = 1'b0;
        if (req_valid) begin
          if (!cfg_ok) begin
            phase_d = PH_DONE;
            err_d   = 1'b1;
          end else if (req_internal) begin
            phase_d = PH_DONE;
          end else begin
            phase_d  = PH_ADDR;
            wr_d     = req_write;
            load_ext = 1'b1;
          end
        end
      end
      PH_ADDR: phase_d = PH_TURN;
      PH_TURN: phase_d = PH_DAT1;
      PH_DAT1: phase_d = PH_DAT2;
      PH_DAT2: phase_d = PH_DONE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
      err_q   <= err_d;
    end
  end

  assign in_data = (phase_q == PH_DAT1) || (phase_q == PH_DAT2);
  assign phase   = phase_q;
  assign wr_cyc  = wr_q;
  assign capture = (phase_q == PH_DAT2) && !wr_q;
  assign ready   = (phase_q == PH_IDLE);
  assign ale     = (phase_q == PH_ADDR);
  assign rd_n    = !(in_data && !wr_q);
  assign wr_n    = !(in_data && wr_q);
  assign done    = (phase_q == PH_DONE);
  assign err     = (phase_q == PH_DONE) && err_q;

  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r3_ale_then_turn: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && rd_n && wr_n));
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ready));
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

endmodule

// File: rtl/xbus_pinmux.sv
module xbus_pinmux
  import xbus_pkg::*;
#(
  parameter int PW = 8,
  localparam int AW = 3 * PW,
  localparam int DW = 2 * PW
) (
  input  layout_e       layout,
  input  phase_e        phase,
  input  logic          wr_cyc,
  input  logic [AW-1:0] addr_h,
  input  logic [DW-1:0] wdata_h,
  output logic [PW-1:0] p0_out,
  output logic          p0_oe,
  output logic [PW-1:0] p1_out,
  output logic          p1_oe,
  output logic [PW-1:0] p2_out,
  output logic          p2_oe
);

  logic cfgd, p1_shared, p1_dedic, p2_upper, a_phase, w_phase;

  assign cfgd      = (layout != LAY_OFF);
  assign p1_shared = (layout == LAY_A24_D16) || (layout == LAY_A8_D16);
  assign p1_dedic  = (layout == LAY_A24_D8)  || (layout == LAY_A16_D8);
  assign p2_upper  = (layout == LAY_A24_D8)  || (layout == LAY_A24_D16);
  assign a_phase   = (phase == PH_ADDR);
  assign w_phase   = wr_cyc && ((phase == PH_DAT1) || (phase == PH_DAT2));

  always_comb begin
    p0_oe  = cfgd && (a_phase || w_phase);
    p0_out = a_phase ? addr_h[PW-1:0] : wdata_h[PW-1:0];

    p1_oe  = 1'b0;
    p1_out = addr_h[2*PW-1:PW];
    if (p1_dedic) begin
      p1_oe = 1'b1;
    end else if (p1_shared) begin
      p1_oe  = a_phase || w_phase;
      p1_out = a_phase ? addr_h[2*PW-1:PW] : wdata_h[2*PW-1:PW];
    end

    p2_oe  = cfgd;
    p2_out = p2_upper ? addr_h[3*PW-1:2*PW] : addr_h[PW-1:0];
  end

endmodule

// File: rtl/xbus_mux_ctrl.sv
module xbus_mux_ctrl
  import xbus_pkg::*;
#(
  parameter int PW = 8,
  localparam int AW = 3 * PW,
  localparam int DW = 2 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_p1_fn,
  input  logic          cfg_p1_ctl,
  input  logic          cfg_p2_fn,
  input  logic          cfg_p2_ctl,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_internal,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  input  logic [PW-1:0] p0_in,
  output logic [PW-1:0] p0_out,
  output logic          p0_oe,
  input  logic [PW-1:0] p1_in,
  output logic [PW-1:0] p1_out,
  output logic          p1_oe,
  input  logic [PW-1:0] p2_in,
  output logic [PW-1:0] p2_out,
  output logic          p2_oe
);

  logic [1:0]    rst_pipe;
  logic          rst_core_n;
  layout_e       layout;
  phase_e        phase;
  logic          wr_cyc, load_ext, capture, wide;
  logic [AW-1:0] addr_h;
  logic [DW-1:0] wdata_h, rdata_q, rdata_d;
  logic          p2_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  xbus_cfg_decode u_dec (
    .p1_fn (cfg_p1_fn),
    .p1_ctl(cfg_p1_ctl),
    .p2_fn (cfg_p2_fn),
    .p2_ctl(cfg_p2_ctl),
    .layout(layout)
  );

  xbus_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_internal(req_internal),
    .cfg_ok      (layout != LAY_OFF),
    .phase       (phase),
    .wr_cyc      (wr_cyc),
    .load_ext    (load_ext),
    .capture     (capture),
    .ready       (ready),
    .ale         (ale),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .done        (done),
    .err         (err)
  );

  assign wide    = (layout == LAY_A24_D16) || (layout == LAY_A8_D16);
  assign rdata_d = wide ? {p1_in, p0_in} : {{PW{1'b0}}, p0_in};

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      addr_h  <= '0;
      wdata_h <= '0;
      rdata_q <= '0;
    end else begin
      if (load_ext) begin
        addr_h  <= req_addr;
        wdata_h <= req_wdata;
      end
      if (capture) rdata_q <= rdata_d;
    end
  end
  assign rdata     = rdata_q;
  assign p2_unused = ^p2_in;

  xbus_pinmux #(.PW(PW)) u_pin (
    .layout (layout),
    .phase  (phase),
    .wr_cyc (wr_cyc),
    .addr_h (addr_h),
    .wdata_h(wdata_h),
    .p0_out (p0_out),
    .p0_oe  (p0_oe),
    .p1_out (p1_out),
    .p1_oe  (p1_oe),
    .p2_out (p2_out),
    .p2_oe  (p2_oe)
  );

  a_r2_off_no_drive: assert property (@(posedge clk) disable iff (!rst_core_n)
    (layout == LAY_OFF) |-> !(p0_oe || p1_oe || p2_oe));
  a_r8_dedic_p1_on: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((layout == LAY_A24_D8) || (layout == LAY_A16_D8)) |-> p1_oe);
  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_n |-> !p0_oe);

endmodule

// File: tb/xbus_mux_ctrl_tb.sv
module xbus_mux_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_p1_fn = 0, cfg_p1_ctl = 0, cfg_p2_fn = 0, cfg_p2_ctl = 0;
  logic req_valid = 0, req_write = 0, req_internal = 0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic ready, done, err, ale, rd_n, wr_n;
  logic [15:0] rdata;
  logic [7:0] p0_in = '0, p1_in = '0, p2_in = '0;
  logic [7:0] p0_out, p1_out, p2_out;
  logic p0_oe, p1_oe, p2_oe;

  always #4 clk = ~clk;

  xbus_mux_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_p1_fn(cfg_p1_fn), .cfg_p1_ctl(cfg_p1_ctl),
    .cfg_p2_fn(cfg_p2_fn), .cfg_p2_ctl(cfg_p2_ctl),
    .req_valid(req_valid), .req_write(req_write), .req_internal(req_internal),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .done(done), .err(err), .rdata(rdata),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
    .p1_in(p1_in), .p1_out(p1_out), .p1_oe(p1_oe),
    .p2_in(p2_in), .p2_out(p2_out), .p2_oe(p2_oe)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  // reference model state
  int          m_ph = 0;
  bit          m_w = 0, m_err = 0, m_int = 0;
  logic [23:0] m_addr = '0;
  logic [15:0] m_wd = '0, m_rd = '0;

  function automatic int lay_of(bit f1, bit c1, bit f2, bit c2);
    if (!(f1 && f2)) return 0;
    if (!c1 && c2) return 1;
    if (c1 && c2)  return 2;
    if (!c1 && !c2) return 3;
    return 4;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ph = 0; m_w = 0; m_err = 0; m_int = 0; m_addr = '0; m_wd = '0; m_rd = '0;
    end else begin
      int ly;
      ly = lay_of(cfg_p1_fn, cfg_p1_ctl, cfg_p2_fn, cfg_p2_ctl);
      case (m_ph)
        0: if (req_valid) begin
             m_err = 0;
             if (ly == 0) begin m_ph = 5; m_err = 1; end
             else if (req_internal) begin m_ph = 5; m_int = 1; end
             else begin
               m_ph = 1; m_int = 0; m_w = req_write; m_addr = req_addr; m_wd = req_wdata;
             end
           end
        4: begin
             if (!m_w) m_rd = (ly == 2 || ly == 4) ? {p1_in, p0_in} : {8'h00, p0_in};
             m_ph = 5;
           end
        5: begin m_ph = 0; m_err = 0; end
        default: m_ph = m_ph + 1;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      int ly;
      bit dat, e_oe0, e_oe1, e_oe2;
      string tp, td;
      ly  = lay_of(cfg_p1_fn, cfg_p1_ctl, cfg_p2_fn, cfg_p2_ctl);
      dat = (m_ph == 3 || m_ph == 4);
      chk("R3", "ale", ale, m_ph == 1);
      chk("R3", "rd_n", rd_n, !(dat && !m_w));
      chk("R3", "wr_n", wr_n, !(dat && m_w));
      chk("R4", "done", done, m_ph == 5);
      chk("R4", "ready", ready, m_ph == 0);
      chk("R10", "err", err, (m_ph == 5) && m_err);
      if (m_ph == 5 && !m_err && !m_int && !m_w) chk("R5", "rdata", rdata, m_rd);
      tp = (ly == 0) ? "R2" : (m_ph == 1) ? "R7" : dat ? "R6" : m_int ? "R9" : "R3";
      td = (ly == 0) ? "R2" : m_int ? "R9" : "R8";
      e_oe0 = (ly != 0) && (m_ph == 1 || (dat && m_w));
      chk(tp, "p0_oe", p0_oe, e_oe0);
      if (e_oe0) chk(tp, "p0_out", p0_out, (m_ph == 1) ? m_addr[7:0] : m_wd[7:0]);
      if (ly == 2 || ly == 4) begin
        e_oe1 = (m_ph == 1 || (dat && m_w));
        chk(tp, "p1_oe", p1_oe, e_oe1);
        if (e_oe1) chk(tp, "p1_out", p1_out, (m_ph == 1) ? m_addr[15:8] : m_wd[15:8]);
      end else if (ly == 1 || ly == 3) begin
        chk(td, "p1_oe", p1_oe, 1);
        chk(td, "p1_out", p1_out, m_addr[15:8]);
      end else chk("R2", "p1_oe", p1_oe, 0);
      e_oe2 = (ly != 0);
      chk(td, "p2_oe", p2_oe, e_oe2);
      if (e_oe2) chk(td, "p2_out", p2_out, (ly <= 2) ? m_addr[23:16] : m_addr[7:0]);
      p0_in <= 8'h3c ^ 8'(cycles * 7);
      p1_in <= 8'hc5 ^ 8'(cycles * 13);
      p2_in <= 8'(cycles);
    end
  end

  task automatic set_cfg(bit f1, bit c1, bit f2, bit c2);
    @(negedge clk);
    cfg_p1_fn = f1; cfg_p1_ctl = c1; cfg_p2_fn = f2; cfg_p2_ctl = c2;
  endtask

  task automatic do_req(logic [23:0] a, logic [15:0] d, bit w, bit in);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_wdata = d; req_write = w; req_internal = in;
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~d;
    while (m_ph != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk("R1", "ale", ale, 0);
    chk("R1", "strobes", {rd_n, wr_n}, 2'b11);
    chk("R1", "done/err", {done, err}, 2'b00);
    chk("R1", "oe", {p0_oe, p1_oe, p2_oe}, 3'b000);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "ready", ready, 1);
    // R10: unconfigured requests
    do_req(24'h112233, 16'h4455, 0, 0);
    do_req(24'h010203, 16'h0405, 1, 0);
    // R2: illegal combinations stay off
    set_cfg(0, 1, 1, 1);
    do_req(24'h0a0b0c, 16'h0d0e, 0, 0);
    set_cfg(1, 0, 0, 1);
    do_req(24'h0a0b0c, 16'h0d0e, 1, 0);
    // layout 1: 24-bit address, 8-bit data
    set_cfg(1, 0, 1, 1);
    do_req(24'habcdef, 16'h1234, 1, 0);
    do_req(24'h123456, 16'h0000, 0, 0);
    do_req(24'h999999, 16'h7777, 0, 1);  // R9 internal keeps address
    do_req(24'h888888, 16'h6666, 1, 1);
    // layout 2: 24-bit address, 16-bit data
    set_cfg(1, 1, 1, 1);
    do_req(24'hfedcba, 16'hbeef, 1, 0);
    do_req(24'h00ff00, 16'h0000, 0, 0);
    do_req(24'h5a5a5a, 16'h1111, 0, 1);
    // layout 3: 16-bit address, 8-bit data
    set_cfg(1, 0, 1, 0);
    do_req(24'h00c3a5, 16'h00e1, 1, 0);
    do_req(24'h007f80, 16'h0000, 0, 0);
    do_req(24'h000000, 16'h2222, 1, 1);
    // layout 4: 8-bit address, 16-bit data
    set_cfg(1, 1, 1, 0);
    do_req(24'h0000ff, 16'hcafe, 1, 0);
    do_req(24'h000001, 16'h0000, 0, 0);
    do_req(24'h000077, 16'h3333, 0, 1);
    // back to off: pins released
    set_cfg(0, 0, 0, 0);
    do_req(24'h123123, 16'h4564, 0, 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule